// File: doc/BRIEF.md
# Ready Warp Issue Scheduler

This block picks, every cycle, at most one warp to issue from a pool of warp contexts (64 by default, each 32 threads wide). A warp takes part only once it has been allocated and its `ready_i` bit is high. `ready_i` means the next instruction of that warp has no outstanding dependency. The block only decides which warp goes next. The execution pipeline and dependency tracking sit outside it.

Two selection policies share one datapath, and `mode_i` chooses between them each cycle:

- **Loose round-robin** rotates to the next ready warp after every grant.
- **Greedy-then-oldest** keeps granting the same warp while it stays ready. When that warp stalls, it falls back to the oldest ready warp.

Age is the order of allocation. The block keeps a compact rank for each live warp, and the rank is updated on every allocation and retirement.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset no warp is allocated and no grant is given. The round-robin search starts at warp 0, and there is no greedy warp yet.
- R2: A warp is eligible when it is allocated and its `ready_i` bit is 1. When any warp is eligible, `grant_valid_o` is 1, `grant_id_o` names an eligible warp, and `grant_onehot_o` has only bit `grant_id_o` set.
- R3: When no warp is eligible, `grant_valid_o` is 0 and `grant_onehot_o` is 0. The last-granted warp register keeps its value.
- R4: When `mode_i`=0 (round-robin), the grant goes to the first eligible warp at index last+1, last+2, and so on, wrapping modulo the pool size. Here last is the most recently granted warp, and that warp is considered last.
- R5: When `mode_i`=1 (greedy-then-oldest), a warp that received the most recent grant and is still eligible is granted again.
- R6: When `mode_i`=1 and the most recently granted warp is not eligible, or there has been no grant since reset, the grant goes to the eligible warp allocated earliest.
- R7: `alloc_i` with a free `alloc_id_i` makes that warp allocated and youngest. An allocation that targets an already allocated warp is ignored, unless that same warp is retired in the same cycle.
- R8: `retire_i` frees `retire_id_i` and removes it from the age order. The remaining warps keep their relative order. Retiring a free warp is ignored.
- R9: Retiring and allocating the same warp in one cycle leaves that warp allocated and makes it youngest.
- R10: Each cycle's grant follows that cycle's `mode_i`. Changing the mode does not change allocation or age order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | 0 = round-robin, 1 = greedy-then-oldest |
| ready_i | input | N_WARPS | Per-warp: next instruction has no outstanding dependency |
| alloc_i | input | 1 | Allocate request |
| alloc_id_i | input | log2(N_WARPS) | Warp to allocate |
| retire_i | input | 1 | Retire request |
| retire_id_i | input | log2(N_WARPS) | Warp to retire |
| grant_valid_o | output | 1 | A warp is granted this cycle |
| grant_id_o | output | log2(N_WARPS) | Index of the granted warp |
| grant_onehot_o | output | N_WARPS | One-hot form of the grant |

## Verification
The hardest situation to reach is the greedy-then-oldest fallback after the age order has been reshuffled. This needs a stalled greedy warp, several warps retired out of the middle of the order, and a slot reused through a same-cycle retire and allocate.

Directed sequences allocate warps in a scrambled index order so that age differs from index. They then stall the greedy warp, retire mid-order warps, and recycle slots. A long randomized phase follows, with sparse ready vectors and mode flips. The behavioural queue model checks the grant on every cycle of that phase.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;
  typedef enum logic {
    POL_RR  = 1'b0,
    POL_GTO = 1'b1
  } sched_pol_e;
endpackage

// File: rtl/warp_age_table.sv
// Compact age ranks: 0 = oldest live warp, count-1 = youngest.
module warp_age_table #(
  parameter int N   = 64,
  localparam int IW = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [IW-1:0]     alloc_id_i,
  input  logic              retire_i,
  input  logic [IW-1:0]     retire_id_i,
  output logic [N-1:0]      valid_o,
  output logic [N-1:0][IW-1:0] rank_o
);
  logic [N-1:0]         valid_q;
  logic [N-1:0][IW-1:0] rank_q;
  logic [IW:0]          cnt_q;
  logic                 ret_ok, alloc_ok;
  logic [IW-1:0]        ret_rank;
  logic [IW:0]          new_rank;

  assign ret_ok   = retire_i && valid_q[retire_id_i];
  assign alloc_ok = alloc_i && (!valid_q[alloc_id_i] || (ret_ok && retire_id_i == alloc_id_i));
  assign ret_rank = rank_q[retire_id_i];
  assign new_rank = cnt_q - {{IW{1'b0}}, ret_ok};

  for (genvar w = 0; w < N; w++) begin : g_ent
    logic is_ret, is_alloc;
    assign is_ret   = ret_ok && (retire_id_i == IW'(w));
    assign is_alloc = alloc_ok && (alloc_id_i == IW'(w));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[w] <= 1'b0;
        rank_q[w]  <= '0;
      end else begin
        valid_q[w] <= (valid_q[w] && !is_ret) || is_alloc;
        if (is_alloc)
          rank_q[w] <= new_rank[IW-1:0];
        else if (valid_q[w] && ret_ok && !is_ret && rank_q[w] > ret_rank)
          rank_q[w] <= rank_q[w] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q - {{IW{1'b0}}, ret_ok} + {{IW{1'b0}}, alloc_ok};
  end

  assign valid_o = valid_q;
  assign rank_o  = rank_q;
endmodule

// File: rtl/warp_rr_pick.sv
// First set bit strictly after ptr_i, wrapping; ptr_i itself is checked last.
module warp_rr_pick #(
  parameter int N   = 64,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  elig_i,
  input  logic [IW-1:0] ptr_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N; i >= 1; i--) begin
      logic [IW-1:0] cand;
      cand = ptr_i + IW'(i);
      if (elig_i[cand]) begin
        found_o = 1'b1;
        idx_o   = cand;
      end
    end
  end
endmodule

// File: rtl/warp_oldest_pick.sv
module warp_oldest_pick #(
  parameter int N   = 64,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]         elig_i,
  input  logic [N-1:0][IW-1:0] rank_i,
  output logic                 found_o,
  output logic [IW-1:0]        idx_o
);
  logic [IW-1:0] best;
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best    = '1;
    for (int w = 0; w < N; w++) begin
      if (elig_i[w] && (!found_o || rank_i[w] < best)) begin
        found_o = 1'b1;
        idx_o   = IW'(w);
        best    = rank_i[w];
      end
    end
  end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import warp_sched_pkg::*;
#(
  parameter int N_WARPS = 64,
  localparam int IW     = $clog2(N_WARPS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_i,
  input  logic [N_WARPS-1:0] ready_i,
  input  logic               alloc_i,
  input  logic [IW-1:0]      alloc_id_i,
  input  logic               retire_i,
  input  logic [IW-1:0]      retire_id_i,
  output logic               grant_valid_o,
  output logic [IW-1:0]      grant_id_o,
  output logic [N_WARPS-1:0] grant_onehot_o
);
  logic [N_WARPS-1:0]         valid;
  logic [N_WARPS-1:0][IW-1:0] rank;
  logic [N_WARPS-1:0]         elig;
  logic                       rr_found, old_found, sticky;
  logic [IW-1:0]              rr_idx, old_idx;
  // Shared by both policies: rotate pointer in RR, greedy warp in GTO.
  logic [IW-1:0]              last_q;
  logic                       have_last_q;
  sched_pol_e                 pol;

  warp_age_table #(.N(N_WARPS)) u_age (
    .clk_i, .rst_ni, .alloc_i, .alloc_id_i, .retire_i, .retire_id_i,
    .valid_o(valid), .rank_o(rank)
  );

  assign elig = ready_i & valid;
  assign pol  = sched_pol_e'(mode_i);

  warp_rr_pick #(.N(N_WARPS)) u_rr (
    .elig_i(elig), .ptr_i(last_q), .found_o(rr_found), .idx_o(rr_idx)
  );

  warp_oldest_pick #(.N(N_WARPS)) u_old (
    .elig_i(elig), .rank_i(rank), .found_o(old_found), .idx_o(old_idx)
  );

  assign sticky = have_last_q && elig[last_q];

  always_comb begin
    if (pol == POL_RR) begin
      grant_valid_o = rr_found;
      grant_id_o    = rr_idx;
    end else if (sticky) begin
      grant_valid_o = 1'b1;
      grant_id_o    = last_q;
    end else begin
      grant_valid_o = old_found;
      grant_id_o    = old_idx;
    end
    grant_onehot_o = '0;
    if (grant_valid_o) grant_onehot_o[grant_id_o] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q      <= IW'(N_WARPS - 1);
      have_last_q <= 1'b0;
    end else if (grant_valid_o) begin
      last_q      <= grant_id_o;
      have_last_q <= 1'b1;
    end
  end
endmodule

// File: rtl/warp_issue_sched_chk.sv
module warp_issue_sched_chk #(
  parameter int N_WARPS = 64,
  localparam int IW     = $clog2(N_WARPS)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               mode_i,
  input logic [N_WARPS-1:0] ready_i,
  input logic               retire_i,
  input logic [IW-1:0]      retire_id_i,
  input logic               grant_valid_o,
  input logic [IW-1:0]      grant_id_o,
  input logic [N_WARPS-1:0] grant_onehot_o
);
  // R2: grant is one-hot and agrees with the index and valid
  a_r2_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_onehot_o) && (grant_valid_o == (grant_onehot_o != '0)));
  a_r2_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> grant_onehot_o[grant_id_o]);
  // R2: only a ready warp is granted
  a_r2_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_onehot_o & ~ready_i) == '0);
  // R3: no ready warp, no grant
  a_r3_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i == '0) |-> !grant_valid_o);
  // R5: greedy warp keeps issuing while it stays ready and allocated
  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(grant_valid_o) && $past(mode_i) && mode_i &&
     ready_i[$past(grant_id_o)] &&
     !($past(retire_i) && $past(retire_id_i) == $past(grant_id_o)))
    |-> (grant_valid_o && grant_id_o == $past(grant_id_o)));
endmodule

bind warp_issue_sched warp_issue_sched_chk #(.N_WARPS(N_WARPS)) u_chk (
  .clk_i, .rst_ni, .mode_i, .ready_i, .retire_i, .retire_id_i,
  .grant_valid_o, .grant_id_o, .grant_onehot_o
);

// File: tb/warp_issue_sched_test.sv
`timescale 1ns/1ps
module warp_issue_sched_test;
  localparam int N  = 64;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode;
  logic [N-1:0]  ready;
  logic          alloc, retire;
  logic [IW-1:0] alloc_id, retire_id;
  logic          gv;
  logic [IW-1:0] gid;
  logic [N-1:0]  goh;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // behavioural model state
  bit m_valid[N];
  int age_q[$];
  int m_last;
  bit m_have;

  always #2.5 clk = ~clk;

  warp_issue_sched #(.N_WARPS(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .ready_i(ready),
    .alloc_i(alloc), .alloc_id_i(alloc_id), .retire_i(retire), .retire_id_i(retire_id),
    .grant_valid_o(gv), .grant_id_o(gid), .grant_onehot_o(goh)
  );

  function automatic void model_grant(output bit v, output int g);
    v = 0; g = 0;
    if (mode == 1'b0) begin
      for (int i = 1; i <= N; i++) begin
        int c;
        c = (m_last + i) % N;
        if (m_valid[c] && ready[c]) begin v = 1; g = c; break; end
      end
    end else if (m_have && m_valid[m_last] && ready[m_last]) begin
      v = 1; g = m_last;
    end else begin
      foreach (age_q[k]) if (ready[age_q[k]]) begin v = 1; g = age_q[k]; break; end
    end
  endfunction

  function automatic void model_update(bit v, int g);
    bit ret_ok, al_ok;
    if (v) begin m_last = g; m_have = 1; end
    ret_ok = retire && m_valid[retire_id];
    al_ok  = alloc && (!m_valid[alloc_id] || (ret_ok && retire_id == alloc_id));
    if (ret_ok) begin
      m_valid[retire_id] = 0;
      foreach (age_q[k]) if (age_q[k] == int'(retire_id)) begin age_q.delete(k); break; end
    end
    if (al_ok) begin
      m_valid[alloc_id] = 1;
      age_q.push_back(int'(alloc_id));
    end
  endfunction

  // Drive inputs at negedge, compare mid-cycle, advance model at posedge.
  task automatic step(input string tag, input bit m, input logic [N-1:0] rdy,
                      input bit al, input int aid, input bit rt, input int rid);
    bit ev; int eg;
    logic [N-1:0] eoh;
    mode = m; ready = rdy; alloc = al; alloc_id = IW'(aid);
    retire = rt; retire_id = IW'(rid);
    #1;
    model_grant(ev, eg);
    eoh = '0;
    if (ev) eoh[eg] = 1'b1;
    total++;
    if (gv !== ev || goh !== eoh || (ev && gid !== IW'(eg))) begin
      bad++;
      $display("FAIL %s: got v=%0b id=%0d oh=%h, expected v=%0b id=%0d oh=%h",
               tag, gv, gid, goh, ev, eg, eoh);
    end
    @(posedge clk);
    model_update(ev, eg);
    @(negedge clk);
  endtask

  function automatic logic [N-1:0] bits(input int a, input int b = -1, input int c = -1);
    logic [N-1:0] r = '0;
    r[a] = 1'b1;
    if (b >= 0) r[b] = 1'b1;
    if (c >= 0) r[c] = 1'b1;
    return r;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < N; w++) m_valid[w] = 0;
    m_last = N - 1; m_have = 0;
    mode = 0; ready = '0; alloc = 0; retire = 0; alloc_id = '0; retire_id = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: nothing allocated, so all-ready gives no grant
    step("R1", 0, '1, 0, 0, 0, 0);
    step("R1", 1, '1, 0, 0, 0, 0);
    // R7: allocate in scrambled order 9,3,40,0,63 (age != index)
    step("R7", 0, '0, 1, 9, 0, 0);
    step("R7", 0, '0, 1, 3, 0, 0);
    step("R7", 0, '0, 1, 40, 0, 0);
    step("R7", 0, '0, 1, 0, 0, 0);
    step("R7", 0, '0, 1, 63, 0, 0);
    // R1/R4: first RR search starts at warp 0
    step("R1", 0, bits(0, 9, 63), 0, 0, 0, 0);
    // R4: rotation and wrap
    step("R4", 0, bits(0, 9, 63), 0, 0, 0, 0);
    step("R4", 0, bits(0, 9, 63), 0, 0, 0, 0);
    step("R4", 0, bits(0, 9, 63), 0, 0, 0, 0);
    step("R4", 0, bits(40), 0, 0, 0, 0);
    // R3: idle holds the pointer
    step("R3", 0, '0, 0, 0, 0, 0);
    step("R3", 1, '0, 0, 0, 0, 0);
    step("R4", 0, bits(3, 63), 0, 0, 0, 0);
    // R2: unallocated ready warp is not eligible
    step("R2", 0, bits(5), 0, 0, 0, 0);
    // R10/R5: switch to GTO, greedy stays on last warp 63
    step("R10", 1, bits(3, 9, 63), 0, 0, 0, 0);
    step("R5", 1, bits(3, 9, 63), 0, 0, 0, 0);
    step("R5", 1, bits(0, 63), 0, 0, 0, 0);
    // R6: 63 stalls, oldest ready among 3,40,0 is 3
    step("R6", 1, bits(3, 40, 0), 0, 0, 0, 0);
    step("R6", 1, bits(40, 0), 0, 0, 0, 0);
    // R8: retire 9 (oldest) and 40; 40 ready but gone
    step("R8", 1, '0, 0, 0, 1, 9);
    step("R8", 1, bits(9), 0, 0, 1, 40);
    step("R8", 1, bits(40, 9, 0), 0, 0, 0, 0);
    // R8: retiring free warp 9 ignored
    step("R8", 1, '0, 0, 0, 1, 9);
    // R7: allocate valid warp 3 ignored (3 stays oldest)
    step("R7", 1, '0, 1, 3, 0, 0);
    step("R7", 1, bits(3, 63), 0, 0, 0, 0);
    // R9: retire+alloc warp 3 together makes it youngest
    step("R9", 1, '0, 1, 3, 1, 3);
    step("R9", 1, bits(3, 63, 0), 0, 0, 0, 0);
    step("R9", 1, bits(3, 63), 0, 0, 0, 0);
    // R10: back to RR, allocation intact
    step("R10", 0, '1, 0, 0, 0, 0);
    step("R10", 0, '1, 0, 0, 0, 0);
    // randomized mix
    for (int n = 0; n < 6000; n++) begin
      logic [N-1:0] r;
      bit m;
      for (int w = 0; w < N; w++) r[w] = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 7) == 0) r = '0;
      m = (n / 200) % 2 == 1;
      if ($urandom_range(0, 15) == 0) m = !m;
      step(m ? "R5/R6" : "R4", m, r,
           $urandom_range(0, 2) == 0, $urandom_range(0, N - 1),
           $urandom_range(0, 3) == 0, $urandom_range(0, N - 1));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule